// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a group of completion queues that share one interrupt vector. By default there are two queues, one for receive completions and one for transmit completions. Each queue reports newly written entries with a valid pulse and a count. Software reports the entries it has consumed with a decrement strobe that names the queue and the number of entries. The block keeps a pending count for each queue. From these it derives the total number of pending entries and the number of queues that hold at least one entry.

An interrupt status bit is set by either of two conditions. The count condition holds when the total pending count goes above a programmed entry threshold. The time condition holds when entries have been pending for a programmed number of 100 ns ticks and enough queues hold entries. The output interrupt is a level: the status bit gated by an enable bit. Software writes four registers through one write port: the packed wait register, an enable-set register, an enable-clear register and a status-clear register. It services the queues, decrements the counts and then clears the status bit.

Top module: `cq_coalescer`

## Requirements
- R1: After reset, irq_o, stat_o, ena_o, pend_cnt_o and busy_q_o are all zero, and the wait register is zero.
- R2: Each queue's count rises by cq_add_num on a cq_add_vld pulse and falls by dec_num when dec_vld names it (dec_idx). An add and a decrement to the same queue in the same cycle are both applied. A decrement larger than the count leaves zero. pend_cnt_o is the sum of the queue counts and is visible the cycle after the update.
- R3: busy_q_o equals the number of queues whose count is nonzero.
- R4: The wait register is written with cfg_sel=0. Its bits 31:0 hold the entry threshold. stat_o sets on the clock edge after pend_cnt_o becomes strictly greater than that threshold. A count equal to the threshold does not set it.
- R5: Wait register bits 63:48 hold the time threshold T, in ticks of TICK_CYCLES clocks. Bits 47:32 hold the queue threshold Q. When Q is nonzero and busy_q_o is at least Q, stat_o sets on the edge 5·T+1 cycles after the edge at which the pending count turned nonzero (TICK_CYCLES=5).
- R6: When Q is zero, the time condition never sets stat_o. When busy_q_o is below Q, the time condition does not set stat_o either.
- R7: When the pending count returns to zero, the elapsed time restarts. A new pending period is timed from its own start.
- R8: A write with cfg_sel=1 and bit 0 set makes ena_o 1. A write with cfg_sel=2 and bit 0 set makes ena_o 0. A write with bit 0 clear to either register leaves ena_o unchanged.
- R9: irq_o is high exactly while both stat_o and ena_o are high. It stays high until one of them falls.
- R10: A write with cfg_sel=3 and bit 0 set clears stat_o for one cycle. If a trigger condition still holds, stat_o sets again on the next edge. A write with bit 0 clear has no effect. Without such a clear, stat_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 wait, 1 enable set, 2 enable clear, 3 status clear |
| cfg_wdata | input | 64 | Write data |
| cq_add_vld | input | NUM_CQ | Per-queue new-entry pulse |
| cq_add_num | input | NUM_CQ*ADD_W | Per-queue count of new entries |
| dec_vld | input | 1 | Consumed-entry strobe |
| dec_idx | input | IDX_W | Queue index being decremented |
| dec_num | input | ADD_W | Number of entries consumed |
| irq_o | output | 1 | Level interrupt |
| stat_o | output | 1 | Interrupt status bit |
| ena_o | output | 1 | Interrupt enable bit |
| pend_cnt_o | output | PEND_W | Total pending entries |
| busy_q_o | output | BUSY_W | Number of queues holding entries |

## Verification
The bench probes the threshold boundary. A count equal to the entry threshold must stay quiet, so a design that compares with greater-or-equal would interrupt one entry early. It times the tick window to the exact cycle, which would expose a prescaler that is off by one, and it keeps the queue count below Q, which would expose a design that fires on time alone. It restarts a pending period partway through the window, where a timer that is never reset would fire about ten cycles too soon. It also clears status while the count condition is still true, where a design that drops the status bit for good would lose the interrupt.

// File: rtl/cq_coalescer.sv
module cq_coalescer #(
  parameter int NUM_CQ      = 2,
  parameter int CNT_W       = 16,
  parameter int ADD_W       = 8,
  parameter int TICK_CYCLES = 5,
  parameter int TICK_W      = 16,
  localparam int IDX_W  = (NUM_CQ > 1) ? $clog2(NUM_CQ) : 1,
  localparam int BUSY_W = $clog2(NUM_CQ + 1),
  localparam int PEND_W = CNT_W + BUSY_W,
  localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [1:0]              cfg_sel,
  input  logic [63:0]             cfg_wdata,
  input  logic [NUM_CQ-1:0]       cq_add_vld,
  input  logic [NUM_CQ*ADD_W-1:0] cq_add_num,
  input  logic                    dec_vld,
  input  logic [IDX_W-1:0]        dec_idx,
  input  logic [ADD_W-1:0]        dec_num,
  output logic                    irq_o,
  output logic                    stat_o,
  output logic                    ena_o,
  output logic [PEND_W-1:0]       pend_cnt_o,
  output logic [BUSY_W-1:0]       busy_q_o
);

  logic [63:0]       wait_q;
  logic [CNT_W-1:0]  cnt_q [NUM_CQ];
  logic [PRE_W-1:0]  pre_q;
  logic [TICK_W-1:0] tick_q;

  wire [15:0] t_thr = wait_q[63:48];
  wire [15:0] q_thr = wait_q[47:32];
  wire [31:0] e_thr = wait_q[31:0];

  for (genvar g = 0; g < NUM_CQ; g++) begin : g_q
    logic [CNT_W+1:0] grown, nxt;
    always_comb begin
      grown = (CNT_W+2)'(cnt_q[g]);
      if (cq_add_vld[g]) grown = grown + (CNT_W+2)'(cq_add_num[g*ADD_W +: ADD_W]);
      nxt = grown;
      if (dec_vld && dec_idx == IDX_W'(g))
        nxt = ((CNT_W+2)'(dec_num) > grown) ? '0 : grown - (CNT_W+2)'(dec_num);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= '0;
      else if (nxt > (CNT_W+2)'({CNT_W{1'b1}})) cnt_q[g] <= '1;
      else cnt_q[g] <= nxt[CNT_W-1:0];
    end
  end

  always_comb begin
    pend_cnt_o = '0;
    busy_q_o   = '0;
    for (int i = 0; i < NUM_CQ; i++) begin
      pend_cnt_o = pend_cnt_o + PEND_W'(cnt_q[i]);
      busy_q_o   = busy_q_o + BUSY_W'(cnt_q[i] != '0);
    end
  end

  wire pend_nz = pend_cnt_o != '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !pend_nz) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_q == PRE_W'(TICK_CYCLES - 1)) begin
      pre_q <= '0;
      if (tick_q != '1) tick_q <= tick_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  wire trig_cnt = 32'(pend_cnt_o) > e_thr;
  wire trig_tim = (q_thr != '0) && pend_nz &&
                  (16'(busy_q_o) >= q_thr) && (32'(tick_q) >= 32'(t_thr));
  wire trig     = trig_cnt || trig_tim;

  wire wr_wait = cfg_wr && cfg_sel == 2'd0;
  wire wr_set  = cfg_wr && cfg_sel == 2'd1 && cfg_wdata[0];
  wire wr_clr  = cfg_wr && cfg_sel == 2'd2 && cfg_wdata[0];
  wire wr_sclr = cfg_wr && cfg_sel == 2'd3 && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
      ena_o  <= 1'b0;
      stat_o <= 1'b0;
    end else begin
      if (wr_wait) wait_q <= cfg_wdata;
      if (wr_set) ena_o <= 1'b1;
      else if (wr_clr) ena_o <= 1'b0;
      stat_o <= wr_sclr ? 1'b0 : (stat_o || trig);
    end
  end

  assign irq_o = stat_o && ena_o;

endmodule

// File: rtl/cq_coalescer_chk.sv
module cq_coalescer_chk #(
  parameter int NUM_CQ = 2,
  parameter int PEND_W = 18,
  parameter int BUSY_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [1:0]        cfg_sel,
  input logic [63:0]       cfg_wdata,
  input logic [31:0]       ethr_i,
  input logic [PEND_W-1:0] pend_cnt_o,
  input logic [BUSY_W-1:0] busy_q_o,
  input logic              stat_o,
  input logic              ena_o
);
  wire sclr = cfg_wr && cfg_sel == 2'd3 && cfg_wdata[0];
  wire eset = cfg_wr && cfg_sel == 2'd1 && cfg_wdata[0];
  wire eclr = cfg_wr && cfg_sel == 2'd2 && cfg_wdata[0];

  a_r4_count_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pend_cnt_o) > ethr_i && !sclr) |=> stat_o);
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> !stat_o);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !sclr) |=> stat_o);
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    eset |=> ena_o);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    eclr |=> !ena_o);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(eset || eclr) |=> $stable(ena_o));
  a_r3_busy_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(busy_q_o) <= NUM_CQ);
endmodule

bind cq_coalescer cq_coalescer_chk #(.NUM_CQ(NUM_CQ), .PEND_W(PEND_W), .BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .ethr_i(wait_q[31:0]), .pend_cnt_o(pend_cnt_o), .busy_q_o(busy_q_o),
  .stat_o(stat_o), .ena_o(ena_o)
);

// File: tb/cq_coalescer_tb_top.sv
module cq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic [1:0]  cq_add_vld = '0;
  logic [15:0] cq_add_num = '0;
  logic        dec_vld = 1'b0;
  logic [0:0]  dec_idx = '0;
  logic [7:0]  dec_num = '0;
  logic        irq_o, stat_o, ena_o;
  logic [17:0] pend_cnt_o;
  logic [1:0]  busy_q_o;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cq_coalescer dut_i (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] sel, logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push_dec(logic [1:0] vld, logic [7:0] n0, logic [7:0] n1,
                          logic dv, logic di, logic [7:0] dn);
    @(negedge clk);
    cq_add_vld = vld; cq_add_num = {n1, n0};
    dec_vld = dv; dec_idx = di; dec_num = dn;
    @(negedge clk);
    cq_add_vld = '0; dec_vld = 1'b0;
  endtask

  task automatic push(int q, logic [7:0] n);
    if (q == 0) push_dec(2'b01, n, 8'd0, 1'b0, 1'b0, 8'd0);
    else        push_dec(2'b10, 8'd0, n, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic dec(int q, logic [7:0] n);
    push_dec(2'b00, 8'd0, 8'd0, 1'b1, q[0], n);
  endtask

  function automatic logic [63:0] wv(int t, int q, int e);
    return {t[15:0], q[15:0], e[31:0]};
  endfunction

  task automatic t_reset();
    check("R1 irq", irq_o, 0);
    check("R1 stat", stat_o, 0);
    check("R1 ena", ena_o, 0);
    check("R1 pend", pend_cnt_o, 0);
    check("R1 busy", busy_q_o, 0);
  endtask

  task automatic t_enable();
    cfg(2'd1, 64'd0); check("R8 set-zero ignored", ena_o, 0);
    cfg(2'd1, 64'd1); check("R8 set", ena_o, 1);
    cfg(2'd2, 64'd0); check("R8 clr-zero ignored", ena_o, 1);
    cfg(2'd2, 64'd1); check("R8 clr", ena_o, 0);
  endtask

  task automatic t_counts();
    cfg(2'd0, wv(0, 0, 1000));
    push(0, 3); check("R2 pend q0", pend_cnt_o, 3); check("R3 busy one", busy_q_o, 1);
    push(1, 2); check("R2 pend both", pend_cnt_o, 5); check("R3 busy two", busy_q_o, 2);
    dec(0, 5);  check("R2 floor zero", pend_cnt_o, 2); check("R3 busy after floor", busy_q_o, 1);
    push_dec(2'b01, 8'd4, 8'd0, 1'b1, 1'b0, 8'd1);
    check("R2 add+dec same cycle", pend_cnt_o, 5);
    dec(0, 3); dec(1, 2);
    check("R2 drained", pend_cnt_o, 0); check("R3 busy none", busy_q_o, 0);
    check("R4 no stat below thr", stat_o, 0);
  endtask

  task automatic t_entry();
    cfg(2'd0, wv(0, 0, 2));
    cfg(2'd1, 64'd1);
    push(0, 2); idle(2);
    check("R4 equal no trigger", stat_o, 0);
    push(1, 1);
    check("R4 not same cycle", stat_o, 0);
    idle(1);
    check("R4 above thr", stat_o, 1);
    check("R9 irq high", irq_o, 1);
    cfg(2'd3, 64'd1);
    check("R10 cleared", stat_o, 0);
    idle(1);
    check("R10 re-assert", stat_o, 1);
    cfg(2'd2, 64'd1);
    check("R9 irq gated", irq_o, 0);
    dec(0, 2); dec(1, 1);
    cfg(2'd3, 64'd0);
    check("R10 zero write ignored", stat_o, 1);
    cfg(2'd3, 64'd1); idle(2);
    check("R10 stays clear", stat_o, 0);
    cfg(2'd1, 64'd1);
    check("R9 irq low", irq_o, 0);
  endtask

  task automatic t_timer();
    cfg(2'd0, wv(3, 1, 1000));
    push(0, 1);
    idle(15); check("R5 before window", stat_o, 0);
    idle(1);  check("R5 at window", stat_o, 1);
    check("R9 timer irq", irq_o, 1);
    dec(0, 1); cfg(2'd3, 64'd1);
  endtask

  task automatic t_qthr();
    cfg(2'd0, wv(1, 0, 1000));
    push(0, 1); idle(20);
    check("R6 qthr zero disables", stat_o, 0);
    dec(0, 1);
    cfg(2'd0, wv(1, 2, 1000));
    push(0, 1); idle(20);
    check("R6 too few queues", stat_o, 0);
    push(1, 1); idle(1);
    check("R6 enough queues", stat_o, 1);
    dec(0, 1); dec(1, 1); cfg(2'd3, 64'd1);
  endtask

  task automatic t_restart();
    cfg(2'd0, wv(3, 1, 1000));
    push(0, 1); idle(10);
    dec(0, 1);
    push(0, 1);
    idle(15); check("R7 timer restarted", stat_o, 0);
    idle(1);  check("R7 fires from new start", stat_o, 1);
    dec(0, 1); cfg(2'd3, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_counts();
    t_entry();
    t_timer();
    t_qthr();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule